// File: doc/BRIEF.md
# Register Slave with Programmable Wait States

This block is a memory-mapped slave port placed in front of a small array of internal registers. A master starts a single-word read or a single-word write. The slave answers by raising a stall flag, `stall_o`, in the same cycle the request appears. It keeps the flag high for a fixed number of wait cycles, set by the parameter `WAIT_CYCLES`. The transfer completes on the first rising clock edge at which the stall flag is low. Reads and writes are stalled in exactly the same way.

A write is stored at its completing edge. Only the byte lanes whose enable bit is set are changed. A read is accepted at its completing edge, and its data comes back in the following cycle on `rdata_o`, marked by a one-cycle `rvalid_o` pulse. The word width and the register count are parameters. The master must hold its address, enables, data and command steady while the stall flag is high. It must never request a read and a write in the same cycle.

Top module: `mm_wait_slave`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), every register reads as zero, `rvalid_o` is low, and `stall_o` is low while no request is present.
- R2: When `WAIT_CYCLES` is greater than 0, `stall_o` is high in the very cycle a read or write request first appears.
- R3: Every read and every write sees exactly `WAIT_CYCLES` cycles with `stall_o` high. It completes at the rising edge of the next cycle, in which `stall_o` is low.
- R4: A completed write changes only the byte lanes whose `be_i` bit is 1. Bit i covers data bits 8*i+7 down to 8*i. The other lanes keep their old value, and a write with `be_i` all zero changes nothing.
- R5: After a read completes at an edge, `rvalid_o` is high for the one cycle after that edge, and `rdata_o` then holds the addressed register.
- R6: A write never produces an `rvalid_o` pulse, and `rvalid_o` is low in every cycle that does not follow a completed read.
- R7: A request that follows a completed transfer with no idle cycle between them is stalled for the full `WAIT_CYCLES` again.
- R8: With no request present, `stall_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Register index |
| be_i | input | DATA_W/8 | Byte-lane enables for writes |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, meaningful only while rvalid_o is high |
| rvalid_o | output | 1 | One-cycle read data strobe |
| stall_o | output | 1 | Wait request to the master |

## Verification
If the wait counter holds a wrong value, the stall length visible at the port is wrong for that same transfer. It is too short, too long, or missing in the first cycle of a request. The bench measures the stall of every transfer cycle by cycle. A wrong byte-lane mask or a bad register index in the bank stays hidden until the register is next read. It then shows as a wrong `rdata_o` word in the cycle after that read completes. The mix of partial writes and read-backs is arranged so that each lane and several addresses are read back within a few transfers.

// File: rtl/mm_wait_pkg.sv
package mm_wait_pkg;
  localparam int BYTE_W = 8;

  function automatic int cnt_width(input int limit);
    return $clog2(limit + 2);
  endfunction
endpackage

// File: rtl/mm_wait_ctr.sv
module mm_wait_ctr #(
  parameter int WAIT_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic stall_o,
  output logic accept_o
);
  import mm_wait_pkg::*;
  localparam int CNT_W = cnt_width(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  assign stall_o  = req_i && (cnt_q != LIMIT);
  assign accept_o = req_i && (cnt_q == LIMIT);

  always_ff @(posedge clk_i) begin
    if (rst_i || !req_i || accept_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  // R3
  always_comb begin
    cnt_in_range_chk: assert (rst_i || cnt_q <= LIMIT);
  end

  // R8
  idle_no_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !req_i |-> !stall_o);

  // R3
  stall_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    accept_o |=> (cnt_q == '0));
endmodule

// File: rtl/mm_reg_bank.sv
module mm_reg_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W/8-1:0]        be_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       rvalid_o
);
  import mm_wait_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int b = 0; b < LANES; b++)
        if (be_i[b]) mem_q[addr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= mem_q[addr_i];
    end
  end

  // R5
  rvalid_follows_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_en_i |=> rvalid_o);

  // R6
  no_rvalid_after_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> !rvalid_o);
endmodule

// File: rtl/mm_wait_slave.sv
module mm_wait_slave #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int WAIT_CYCLES = 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic                stall_o
);
  logic req, accept;

  assign req = rd_i || wr_i;

  mm_wait_ctr #(.WAIT_CYCLES(WAIT_CYCLES)) ctr_i (
    .clk_i(clk_i), .rst_i(rst_i), .req_i(req),
    .stall_o(stall_o), .accept_o(accept)
  );

  mm_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(accept && wr_i), .rd_en_i(accept && rd_i),
    .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // R1
  reset_clears_rvalid_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> !rvalid_o);

  // R5
  rvalid_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rvalid_o |-> $past(rd_i && !stall_o));

  // R3
  master_holds_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && stall_o) |=> (rd_i && $stable(addr_i)));

  // R3
  master_holds_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && stall_o) |=> (wr_i && $stable(wdata_i) && $stable(be_i)));
endmodule

// File: tb/mm_wait_slave_tb_top.sv
module mm_wait_slave_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int WAITS  = 2;
  localparam int NVEC   = 11;

  logic clk = 1'b0;
  logic rst;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W/8-1:0] be;
  logic rd, wr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic rvalid, stall;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mm_wait_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_CYCLES(WAITS)) dut_i (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .be_i(be), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .stall_o(stall)
  );

  // entry: {is_read, addr[2:0], be[3:0], data[31:0], expected[31:0]}
  localparam logic [71:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 4'hF, 32'h11223344, 32'h0},
    {1'b0, 3'd1, 4'hF, 32'hAABBCCDD, 32'h0},
    {1'b0, 3'd0, 4'h5, 32'h55667788, 32'h0},
    {1'b1, 3'd0, 4'h0, 32'h0,        32'h11663388},
    {1'b0, 3'd1, 4'h8, 32'hEE000000, 32'h0},
    {1'b1, 3'd1, 4'h0, 32'h0,        32'hEEBBCCDD},
    {1'b0, 3'd2, 4'h0, 32'hFFFFFFFF, 32'h0},
    {1'b1, 3'd2, 4'h0, 32'h0,        32'h00000000},
    {1'b1, 3'd7, 4'h0, 32'h0,        32'h00000000},
    {1'b0, 3'd7, 4'h6, 32'h12345678, 32'h0},
    {1'b1, 3'd7, 4'h0, 32'h0,        32'h00345600}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Called mid-cycle; returns 2 time units after the completing edge.
  task automatic xfer(input logic is_rd, input logic [ADDR_W-1:0] a, input logic [3:0] b,
                      input logic [31:0] d, input logic [31:0] exp);
    int stalls = 0;
    addr = a; be = b; wdata = d; rd = is_rd; wr = !is_rd;
    #1;
    check("R2 stall in first request cycle", 32'(stall), 32'(WAITS > 0));
    while (stall && stalls < 100) begin
      stalls++;
      @(posedge clk); #2;
    end
    check(is_rd ? "R3 read stall count" : "R3 write stall count", 32'(stalls), 32'(WAITS));
    @(posedge clk); #1;
    rd = 1'b0; wr = 1'b0;
    #1;
    if (is_rd) begin
      check("R5 rvalid after read", 32'(rvalid), 32'd1);
      check("R5 read data", rdata, exp);
    end else begin
      check("R6 no rvalid after write", 32'(rvalid), 32'd0);
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; be = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    check("R1 rvalid low after reset", 32'(rvalid), 32'd0);
    check("R8 stall low while idle", 32'(stall), 32'd0);
    @(posedge clk); #2;
    xfer(1'b1, 3'd3, 4'h0, 32'h0, 32'h0);  // R1 reset contents
    @(posedge clk); #2;
    check("R6 rvalid drops after one cycle", 32'(rvalid), 32'd0);
    check("R8 stall low while idle", 32'(stall), 32'd0);
    xfer(1'b1, 3'd5, 4'h0, 32'h0, 32'h0);  // R1

    // back-to-back table walk: each op starts right after the previous completes (R7)
    for (int i = 0; i < NVEC; i++)
      xfer(VEC[i][71], VEC[i][70:68], VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]);

    // R4: single-lane writes to each byte of one register
    xfer(1'b0, 3'd4, 4'h1, 32'hA1A2A3A4, 32'h0);
    xfer(1'b0, 3'd4, 4'h4, 32'hB1B2B3B4, 32'h0);
    xfer(1'b1, 3'd4, 4'h0, 32'h0, 32'h00B200A4);
    @(posedge clk); #2;
    check("R6 no rvalid in idle cycle", 32'(rvalid), 32'd0);

    // R1: reset in mid-run clears registers
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    #1;
    check("R1 rvalid low after second reset", 32'(rvalid), 32'd0);
    xfer(1'b1, 3'd0, 4'h0, 32'h0, 32'h0);
    xfer(1'b1, 3'd7, 4'h0, 32'h0, 32'h0);
    finish_run();
  end
endmodule